// File: doc/BRIEF.md
# Sequential Signed Shift-Add Multiplier

This block multiplies two two's complement operands one multiplier bit per clock cycle, using the plain add-and-shift method without Booth recoding. A double-width product register holds the running partial sum in its upper half and the multiplier in its lower half. Each cycle the lowest multiplier bit is examined, the multiplicand is conditionally combined into the upper half, and the whole register shifts right by one place. The multiplier bits drain out at the bottom while product bits enter from the top.

Two changes make the shift-add scheme correct for signed numbers. The right shift is arithmetic, so the sign of the partial sum is kept in the vacated top bit. The multiplier's top bit has negative weight, so on the final step a set bit subtracts the multiplicand instead of adding it. A one-cycle `start` request latches both operands while the block is idle. `busy` then covers the iterations, and `done` marks the cycle in which the product first becomes valid.

Top module: `smul_top`

## Requirements
- R1: While `rst_n` is low and after its release, `busy` is 0, `done` is 0 and `product` is all zeros until the first accepted start.
- R2: A `start` sampled high while idle is accepted; `busy` is high from the next cycle for exactly WIDTH cycles (4 by default) and then falls.
- R3: `done` is high for exactly one cycle, the first cycle in which `busy` is low again after a run, and is never high together with `busy`.
- R4: When `done` is high, `product` (2*WIDTH bits, two's complement) equals the signed product of `mcand` and `mplier` as sampled at the accepted start, for every operand pair.
- R5: The partial product shifts right arithmetically: a negative multiplicand with a positive multiplier gives a correct negative product, e.g. mcand 4'b1011 (-5) times mplier 4'b0101 (5) gives 8'hE7 (-25).
- R6: A multiplier with its top bit set is weighted negatively, so the last step subtracts the multiplicand: mcand 5 times mplier -5 gives 8'hE7, and -8 times -8 gives 8'h40 (64).
- R7: `start` is ignored while `busy` is high: the run neither restarts nor lengthens, and the product delivered is that of the operands originally accepted.
- R8: After `done`, `product` holds its value while idle until the next accepted start.
- R9: `mcand` and `mplier` are sampled only in the cycle a start is accepted; changing them during a run has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Request a multiplication; accepted only while idle |
| mcand | input | WIDTH | Multiplicand, two's complement |
| mplier | input | WIDTH | Multiplier, two's complement |
| busy | output | 1 | High while the iterations run |
| done | output | 1 | One-cycle pulse when the product is valid |
| product | output | 2*WIDTH | Signed product register |

## Verification
The bench builds the block with the default WIDTH of 4, which makes the operand space only 256 pairs, so every pair is multiplied exhaustively. This covers both sign combinations, the -8 times -8 extreme, and the case of zero. Seeded random runs then drive fresh operands and spurious start pulses during each run. Those runs show that the latched operands alone decide the result and that the busy window stays at four cycles.

// File: rtl/smul_pkg.sv
package smul_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } smul_state_e;
endpackage

// File: rtl/smul_ctrl.sv
module smul_ctrl
  import smul_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step,
  output logic last,
  output logic busy,
  output logic done
);
  localparam int CW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [CW-1:0] LAST_CNT = CW'(WIDTH - 1);

  smul_state_e state_q, state_nxt;
  logic [CW-1:0] cnt_q, cnt_nxt;
  logic          cnt_en;
  logic          done_q, done_nxt;

  always_comb begin
    load = (state_q == ST_IDLE) && start;
    step = (state_q == ST_RUN);
    last = step && (cnt_q == LAST_CNT);
  end

  always_comb begin
    state_nxt = state_q;
    case (state_q)
      ST_IDLE: if (start) state_nxt = ST_RUN;
      ST_RUN:  if (last)  state_nxt = ST_IDLE;
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_en  = load || step;
    cnt_nxt = load ? '0 : cnt_q + CW'(1);
    done_nxt = last;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_nxt;
      done_q  <= done_nxt;
      if (cnt_en) cnt_q <= cnt_nxt;
    end
  end

  assign busy = (state_q == ST_RUN);
  assign done = done_q;

  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= LAST_CNT));
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  assert_done_after_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(busy));
  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last) |=> busy);
endmodule

// File: rtl/smul_addsub.sv
module smul_addsub #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] acc,
  input  logic [WIDTH-1:0] mcand,
  input  logic             use_mcand,
  input  logic             negate,
  output logic [WIDTH:0]   sum
);
  localparam int SW = WIDTH + 1;

  logic [SW-1:0] acc_ext, mc_ext, opnd;
  logic          cin;

  always_comb begin
    acc_ext = {acc[WIDTH-1], acc};
    mc_ext  = {mcand[WIDTH-1], mcand};
    if (!use_mcand)  opnd = '0;
    else if (negate) opnd = ~mc_ext;
    else             opnd = mc_ext;
    cin = use_mcand && negate;
    sum = acc_ext + opnd + SW'(cin);
  end
endmodule

// File: rtl/smul_datapath.sv
module smul_datapath #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic               step,
  input  logic               last,
  input  logic [WIDTH-1:0]   mcand_in,
  input  logic [WIDTH-1:0]   mplier_in,
  output logic [2*WIDTH-1:0] product
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] mcand_q;
  logic [PW-1:0]    prod_q, prod_nxt;
  logic             prod_en;
  logic [WIDTH:0]   part_sum;

  smul_addsub #(.WIDTH(WIDTH)) u_addsub (
    .acc       (prod_q[PW-1:WIDTH]),
    .mcand     (mcand_q),
    .use_mcand (prod_q[0]),
    .negate    (last),
    .sum       (part_sum)
  );

  always_comb begin
    prod_en = load || step;
    if (load) prod_nxt = {{WIDTH{1'b0}}, mplier_in};
    else      prod_nxt = {part_sum, prod_q[WIDTH-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mcand_q <= '0;
      prod_q  <= '0;
    end else begin
      if (load)    mcand_q <= mcand_in;
      if (prod_en) prod_q  <= prod_nxt;
    end
  end

  assign product = prod_q;

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(prod_q));
  assert_mcand_fixed_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(mcand_q));
  assert_sign_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !prod_q[0]) |=> (prod_q[PW-1] == $past(prod_q[PW-1])));
endmodule

// File: rtl/smul_top.sv
module smul_top #(
  parameter int WIDTH = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [WIDTH-1:0]   mcand,
  input  logic [WIDTH-1:0]   mplier,
  output logic               busy,
  output logic               done,
  output logic [2*WIDTH-1:0] product
);
  logic load, step, last;

  smul_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .load  (load),
    .step  (step),
    .last  (last),
    .busy  (busy),
    .done  (done)
  );

  smul_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .step      (step),
    .last      (last),
    .mcand_in  (mcand),
    .mplier_in (mplier),
    .product   (product)
  );

  assert_start_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);
  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!busy && !done));
endmodule

// File: tb/smul_top_bench.sv
module smul_top_bench;
  localparam int W  = 4;
  localparam int PW = 2 * W;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  mcand = '0;
  logic [W-1:0]  mplier = '0;
  logic          busy, done;
  logic [PW-1:0] product;

  int total = 0;
  int bad = 0;
  int seed = 32'h5eed_1234;

  always #4 clk = ~clk;

  smul_top #(.WIDTH(W)) u_smul_top (
    .clk(clk), .rst_n(rst_n), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product)
  );

  function automatic logic [PW-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic signed [PW-1:0] sa, sb;
    sa = {{W{a[W-1]}}, a};
    sb = {{W{b[W-1]}}, b};
    return PW'(sa * sb);
  endfunction

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one multiplication; junk=1 drives random operands and start pulses while busy
  task automatic run_mul(input logic [W-1:0] a, input logic [W-1:0] b, input logic junk,
                         input logic verbose_checks);
    int bcnt;
    logic [PW-1:0] exp;
    exp = ref_mul(a, b);
    @(negedge clk);
    mcand = a; mplier = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    bcnt = 0;
    while (busy && bcnt < 50) begin
      bcnt++;
      if (junk) begin
        mcand  = W'($urandom());
        mplier = W'($urandom());
        start  = 1'($urandom());
      end
      @(negedge clk);
    end
    start = 1'b0;
    if (verbose_checks) begin
      check(bcnt == W, "R2 busy length", bcnt, W);
      check(done == 1'b1 && busy == 1'b0, "R3 done with busy low", {done, busy}, 2'b10);
    end
    if (junk) begin
      check(bcnt == W, "R7 busy length with start pulses", bcnt, W);
      check(product == exp, "R9/R7 product after mid-run input changes", product, exp);
    end else begin
      check(done && product == exp, "R4 signed product", {a, b, product}, {a, b, exp});
    end
    @(negedge clk);
    if (verbose_checks)
      check(done == 1'b0, "R3 done single cycle", done, 0);
  endtask

  initial begin
    #(8 * 200000);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [PW-1:0] held;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && product == 0, "R1 state during reset", {busy, done, product}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(busy == 0 && done == 0 && product == 0, "R1 state after reset", {busy, done, product}, 0);

    run_mul(4'b1011, 4'b0101, 1'b0, 1'b1);
    check(product == 8'hE7, "R5 -5 times 5", product, 8'hE7);
    run_mul(4'b0101, 4'b1011, 1'b0, 1'b1);
    check(product == 8'hE7, "R6 5 times -5", product, 8'hE7);
    run_mul(4'b1000, 4'b1000, 1'b0, 1'b1);
    check(product == 8'h40, "R6 -8 times -8", product, 8'h40);
    run_mul(4'b0111, 4'b1000, 1'b0, 1'b0);
    check(product == 8'hC8, "R6 7 times -8", product, 8'hC8);

    // R8: product holds while idle with inputs moving and no start
    held = product;
    for (int i = 0; i < 5; i++) begin
      mcand = W'(i + 3); mplier = W'(i);
      @(negedge clk);
      check(product == held && !busy, "R8 product holds while idle", product, held);
    end

    // R4: exhaustive operand space
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++)
        run_mul(W'(a), W'(b), 1'b0, 1'b0);

    // R7 and R9: seeded random runs with junk on the inputs while busy
    for (int k = 0; k < 40; k++)
      run_mul(W'($urandom()), W'($urandom()), 1'b1, (k % 8) == 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule